// File: doc/BRIEF.md
# Configurable Multi-Term Multiply-Accumulate Unit

This purely combinational block adds up a list of terms into one result `y_o`. Each term is a product of two operands, or a single operand when the second one has no bits. After the terms, every bit of the increment vector `b_i` adds one to the sum. The number of terms and each term's layout are fixed when the block is built. A single packed parameter, `LAYOUT`, holds the operand widths, whether the term is signed, and whether it is added or subtracted.

All operands arrive packed together on `a_i`. The first term's operands start at bit 0, and each term's first operand comes before its second. The layout word is decoded by constant functions during elaboration, so only the extenders, multipliers and one adder chain exist in hardware. A layout whose fields do not line up with the stated widths stops elaboration.

Top module: `multi_term_mac`

## Requirements
- R1: The four lowest bits of `LAYOUT` (bit 0 least significant) give the field width F. A term record of 2+2F bits follows for each term. Within a record, bit 0 is the signed flag, bit 1 is the subtract flag, the next F bits are the size of the first operand and the last F bits are the size of the second operand, each size least significant bit first.
- R2: Operands are taken from `a_i` in record order from bit 0 upward. Each term takes its first operand and then its second, each with the width its record gives.
- R3: A term whose second operand has size zero is worth its first operand alone, extended or truncated to `Y_WIDTH` bits.
- R4: A term whose second operand has a nonzero size is worth the product of its two operands, kept to its low `Y_WIDTH` bits.
- R5: A set signed flag sign-extends both operands of that term. A clear signed flag zero-extends both.
- R6: A term with its subtract flag set is subtracted from the sum instead of added.
- R7: The sum starts at zero, so all-zero inputs give `y_o` = 0. All arithmetic wraps modulo 2^`Y_WIDTH`.
- R8: Each bit of `b_i` that is 1 adds one, as an unsigned value, to the result. With `B_WIDTH` = 0 the single `b_i` pin has no effect.
- R9: A record whose two sizes are both zero still uses its 2+2F layout bits. It takes no bits of `a_i` and adds nothing to the result.
- R10: Elaboration fails if the records do not use exactly `LAYOUT_BITS` bits, or if their sizes do not add up to `A_WIDTH`.
- R11: With `A_WIDTH` = 0 there are no terms. The single `a_i` pin has no effect, and `y_o` is the count of ones in `b_i` modulo 2^`Y_WIDTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | max(A_WIDTH,1) | All term operands packed together |
| b_i | input | max(B_WIDTH,1) | Bits that each add one |
| y_o | output | Y_WIDTH | Wrapped sum of terms and increments |

## Verification
The bench builds three instances of the block.

The first has a 3-bit field width and five records:
- a signed product of two 4-bit operands;
- an unsigned, subtracted product of a 5-bit and a 3-bit operand;
- a signed single 6-bit operand;
- an empty record;
- an unsigned, subtracted single 3-bit operand.

Its 12-bit result and 5-bit increment vector cover mixed signedness, single operands and the slicing that follows an empty record.

The second has a 4-bit field width and a 6-bit result fed by a signed, subtracted 7×7 product and an unsigned 8×8 product. It has no increment bits, so both overflow and the ignored `b_i` pin come into reach. The third has no terms, a 9-bit increment vector and a 3-bit result, which shows how the count wraps.

// File: rtl/mtmac_pkg.sv
package mtmac_pkg;

    // Largest layout word the decode functions accept
    localparam int LAYOUT_MAX = 2048;
    typedef logic [LAYOUT_MAX-1:0] layout_t;

    // Width of every size field (R1)
    function automatic int field_width(layout_t lay);
        return int'(lay[3:0]);
    endfunction

    // Read an unsigned number stored least significant bit first
    function automatic int read_num(layout_t lay, int pos, int nbits);
        int val;
        val = 0;
        for (int i = 0; i < nbits; i++) begin
            if (lay[pos + i]) val = val | (1 << i);
        end
        return val;
    endfunction

    function automatic int rec_base(int fw, int idx);
        return 4 + idx * (2 + 2 * fw);
    endfunction

    function automatic bit rec_signed(layout_t lay, int idx);
        return lay[rec_base(field_width(lay), idx)];
    endfunction

    function automatic bit rec_sub(layout_t lay, int idx);
        return lay[rec_base(field_width(lay), idx) + 1];
    endfunction

    function automatic int rec_size_a(layout_t lay, int idx);
        int fw;
        fw = field_width(lay);
        return read_num(lay, rec_base(fw, idx) + 2, fw);
    endfunction

    function automatic int rec_size_b(layout_t lay, int idx);
        int fw;
        fw = field_width(lay);
        return read_num(lay, rec_base(fw, idx) + 2 + fw, fw);
    endfunction

    // Records parsed until the operand bus is used up or the layout runs out
    function automatic int count_recs(layout_t lay, int lay_bits, int a_bits);
        int fw;
        int used_a;
        int n;
        fw     = field_width(lay);
        used_a = 0;
        n      = 0;
        while (used_a < a_bits && rec_base(fw, n) + 2 + 2 * fw <= lay_bits) begin
            used_a = used_a + rec_size_a(lay, n) + rec_size_b(lay, n);
            n = n + 1;
        end
        return n;
    endfunction

    // Bus offset of the first operand of record idx (R2)
    function automatic int a_offset(layout_t lay, int idx);
        int off;
        off = 0;
        for (int i = 0; i < idx; i++) begin
            off = off + rec_size_a(lay, i) + rec_size_b(lay, i);
        end
        return off;
    endfunction

endpackage

// File: rtl/mtmac_ext.sv
module mtmac_ext #(
    parameter int IW     = 4,
    parameter int OW     = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [IW-1:0] x_i,
    output logic [OW-1:0] y_o
);
    generate
        if (IW >= OW) begin : g_trunc
            if (IW > OW) begin : g_drop
                logic unused_hi;
                assign unused_hi = ^x_i[IW-1:OW];
            end
            assign y_o = x_i[OW-1:0];
        end else begin : g_widen
            logic fill_d;
            assign fill_d = SIGNED ? x_i[IW-1] : 1'b0;
            assign y_o    = {{(OW - IW){fill_d}}, x_i};
        end
    endgenerate
endmodule

// File: rtl/mtmac_term.sv
module mtmac_term #(
    parameter int WA     = 4,
    parameter int WB     = 4,
    parameter int YW     = 8,
    parameter bit SIGNED = 1'b0,
    parameter bit SUB    = 1'b0,
    localparam int WBP   = (WB > 0) ? WB : 1
) (
    input  logic [WA-1:0]  opa_i,
    input  logic [WBP-1:0] opb_i,
    output logic [YW-1:0]  term_o
);
    logic [YW-1:0] ext_a_d;
    logic [YW-1:0] mag_d;

    mtmac_ext #(.IW(WA), .OW(YW), .SIGNED(SIGNED)) u_ext_a (
        .x_i (opa_i),
        .y_o (ext_a_d)
    );

    generate
        if (WB == 0) begin : g_single
            // R3: the first operand stands alone
            logic unused_b;
            assign unused_b = ^opb_i;
            assign mag_d    = ext_a_d;
        end else begin : g_product
            // R4: product kept at the result width
            logic [YW-1:0] ext_b_d;
            mtmac_ext #(.IW(WB), .OW(YW), .SIGNED(SIGNED)) u_ext_b (
                .x_i (opb_i),
                .y_o (ext_b_d)
            );
            assign mag_d = ext_a_d * ext_b_d;
        end

        // R6: subtracted terms enter the sum negated
        if (SUB) begin : g_neg
            assign term_o = (~mag_d) + YW'(1);
        end else begin : g_pos
            assign term_o = mag_d;
        end
    endgenerate

    // R4
    always_comb begin
        if (opa_i == '0) begin
            zero_operand_chk: assert (term_o == '0)
                else $error("term with zero first operand is nonzero");
        end
    end

    generate
        if (WB == 0 && !SUB && WA < YW) begin : g_sign_chk
            // R5
            always_comb begin
                widen_fill_chk: assert (term_o[YW-1] == (SIGNED & opa_i[WA-1]))
                    else $error("single operand widened with the wrong fill");
            end
        end
    endgenerate
endmodule

// File: rtl/mtmac_popcnt.sv
module mtmac_popcnt #(
    parameter int BW = 4,
    parameter int YW = 8,
    localparam int CW = $clog2(BW + 1)
) (
    input  logic [BW-1:0] bits_i,
    output logic [YW-1:0] count_o
);
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = '0;
        for (int i = 0; i < BW; i++) begin
            cnt_d = cnt_d + CW'(bits_i[i]);
        end
    end

    mtmac_ext #(.IW(CW), .OW(YW), .SIGNED(1'b0)) u_fit (
        .x_i (cnt_d),
        .y_o (count_o)
    );

    // R8
    always_comb begin
        count_range_chk: assert (int'(cnt_d) <= BW && (bits_i != '0 || cnt_d == '0))
            else $error("increment count out of range");
    end
endmodule

// File: rtl/multi_term_mac.sv
module multi_term_mac
    import mtmac_pkg::*;
#(
    parameter int A_WIDTH     = 0,
    parameter int B_WIDTH     = 4,
    parameter int Y_WIDTH     = 8,
    parameter int LAYOUT_BITS = 4,
    parameter logic [LAYOUT_BITS-1:0] LAYOUT = '0,
    localparam int AP = (A_WIDTH > 0) ? A_WIDTH : 1,
    localparam int BP = (B_WIDTH > 0) ? B_WIDTH : 1
) (
    input  logic [AP-1:0]      a_i,
    input  logic [BP-1:0]      b_i,
    output logic [Y_WIDTH-1:0] y_o
);
    localparam layout_t LAY   = layout_t'(LAYOUT);
    localparam int FW         = field_width(LAY);
    localparam int NT         = count_recs(LAY, LAYOUT_BITS, A_WIDTH);
    localparam int NTA        = (NT > 0) ? NT : 1;
    localparam int USED_LAY   = rec_base(FW, NT);
    localparam int USED_A     = a_offset(LAY, NT);

    logic [NTA-1:0][Y_WIDTH-1:0] terms_d;
    logic [Y_WIDTH-1:0]          inc_d;
    logic [Y_WIDTH-1:0]          acc_d;

    // R10: layout consistency is checked at elaboration
    generate
        if (LAYOUT_BITS < 4 || LAYOUT_BITS > LAYOUT_MAX) begin : g_bad_len
            $error("layout word length out of range");
        end
        if (USED_LAY != LAYOUT_BITS) begin : g_bad_lay
            $error("term records do not fill the layout word exactly");
        end
        if (USED_A != A_WIDTH) begin : g_bad_a
            $error("operand sizes do not add up to the operand bus width");
        end
        if (Y_WIDTH < 1) begin : g_bad_y
            $error("result width must be positive");
        end
    endgenerate

    // R1 R2 R9: one slice of the operand bus per record
    generate
        if (A_WIDTH == 0) begin : g_no_a
            logic unused_a;
            assign unused_a = ^a_i;
        end
        if (NT == 0) begin : g_no_terms
            assign terms_d[0] = '0;
        end
        for (genvar gi = 0; gi < NT; gi++) begin : g_term
            localparam int WA  = rec_size_a(LAY, gi);
            localparam int WB  = rec_size_b(LAY, gi);
            localparam int WBP = (WB > 0) ? WB : 1;
            localparam int OFF = a_offset(LAY, gi);
            localparam bit SG  = rec_signed(LAY, gi);
            localparam bit SB  = rec_sub(LAY, gi);
            if (WA == 0) begin : g_empty_a
                // an empty first operand makes the whole term zero
                if (WB > 0) begin : g_skip_b
                    logic unused_slice;
                    assign unused_slice = ^a_i[OFF +: WBP];
                end
                assign terms_d[gi] = '0;
            end else begin : g_live
                logic [WA-1:0]  opa_d;
                logic [WBP-1:0] opb_d;
                assign opa_d = a_i[OFF +: WA];
                if (WB > 0) begin : g_b
                    assign opb_d = a_i[OFF + WA +: WBP];
                end else begin : g_nob
                    assign opb_d = '0;
                end
                mtmac_term #(
                    .WA     (WA),
                    .WB     (WB),
                    .YW     (Y_WIDTH),
                    .SIGNED (SG),
                    .SUB    (SB)
                ) u_term (
                    .opa_i  (opa_d),
                    .opb_i  (opb_d),
                    .term_o (terms_d[gi])
                );
            end
        end
    endgenerate

    // R8 R11: increment bits
    generate
        if (B_WIDTH == 0) begin : g_no_inc
            logic unused_b;
            assign unused_b = ^b_i;
            assign inc_d    = '0;
        end else begin : g_inc
            mtmac_popcnt #(.BW(B_WIDTH), .YW(Y_WIDTH)) u_popcnt (
                .bits_i  (b_i),
                .count_o (inc_d)
            );
        end
    endgenerate

    // R6 R7: wrapped sum, starting from zero
    always_comb begin
        acc_d = '0;
        for (int i = 0; i < NTA; i++) begin
            acc_d = acc_d + terms_d[i];
        end
        y_o = acc_d + inc_d;
    end

    // R7
    always_comb begin
        if (a_i == '0 && b_i == '0) begin
            zero_input_chk: assert (y_o == '0)
                else $error("all-zero inputs give a nonzero result");
        end
    end

    // R8
    always_comb begin
        if (a_i == '0) begin
            bits_only_chk: assert (y_o == inc_d)
                else $error("result differs from increment count with zero operands");
        end
    end
endmodule

// File: tb/multi_term_mac_bench.sv
`timescale 1ns/1ps
module multi_term_mac_bench;

    localparam logic [43:0] LAY0 = {3'd0, 3'd3, 1'b1, 1'b0,
                                    3'd0, 3'd0, 1'b0, 1'b0,
                                    3'd0, 3'd6, 1'b0, 1'b1,
                                    3'd3, 3'd5, 1'b1, 1'b0,
                                    3'd4, 3'd4, 1'b0, 1'b1,
                                    4'd3};
    localparam logic [23:0] LAY1 = {4'd8, 4'd8, 1'b0, 1'b0,
                                    4'd7, 4'd7, 1'b1, 1'b1,
                                    4'd4};
    localparam logic [3:0]  LAY2 = 4'd2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [24:0] a0; logic [4:0] b0; logic [11:0] y0;
    logic [29:0] a1; logic [0:0] b1; logic [5:0]  y1;
    logic [0:0]  a2; logic [8:0] b2; logic [2:0]  y2;

    int n_checks = 0;
    int n_fail   = 0;

    multi_term_mac #(.A_WIDTH(25), .B_WIDTH(5), .Y_WIDTH(12),
                     .LAYOUT_BITS(44), .LAYOUT(LAY0)) u_multi_term_mac (
        .a_i(a0), .b_i(b0), .y_o(y0));
    multi_term_mac #(.A_WIDTH(30), .B_WIDTH(0), .Y_WIDTH(6),
                     .LAYOUT_BITS(24), .LAYOUT(LAY1)) u_multi_term_mac_narrow (
        .a_i(a1), .b_i(b1), .y_o(y1));
    multi_term_mac #(.A_WIDTH(0), .B_WIDTH(9), .Y_WIDTH(3),
                     .LAYOUT_BITS(4), .LAYOUT(LAY2)) u_multi_term_mac_bits (
        .a_i(a2), .b_i(b2), .y_o(y2));

    function automatic logic [63:0] low_mask(int n);
        if (n >= 64) return '1;
        return (64'(1) << n) - 64'(1);
    endfunction

    // Reference model: decodes the layout at run time
    function automatic logic [63:0] ref_mac(logic [63:0] lay, int aw,
                                            logic [63:0] a, logic [63:0] b,
                                            int bw, int yw);
        logic [63:0] acc, va, vb, t;
        int fw, cur, pos, sa, sb;
        bit sg, neg;
        acc = '0;
        fw  = int'(lay[3:0]);
        cur = 4;
        pos = 0;
        while (pos < aw) begin
            sg  = lay[cur];
            neg = lay[cur + 1];
            sa = 0; sb = 0;
            for (int i = 0; i < fw; i++) if (lay[cur + 2 + i])      sa |= (1 << i);
            for (int i = 0; i < fw; i++) if (lay[cur + 2 + fw + i]) sb |= (1 << i);
            cur = cur + 2 + 2 * fw;
            va  = (a >> pos) & low_mask(sa); pos += sa;
            vb  = (b == b) ? ((a >> pos) & low_mask(sb)) : '0; pos += sb;
            if (sg && sa > 0 && va[sa-1]) va = va | ~low_mask(sa);
            if (sg && sb > 0 && vb[sb-1]) vb = vb | ~low_mask(sb);
            t   = (sb == 0) ? va : va * vb;
            acc = neg ? acc - t : acc + t;
        end
        for (int i = 0; i < bw; i++) acc = acc + 64'(b[i]);
        return acc & low_mask(yw);
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply0(logic [24:0] a, logic [4:0] b);
        @(posedge clk); a0 = a; b0 = b; @(negedge clk);
    endtask
    task automatic apply1(logic [29:0] a, logic [0:0] b);
        @(posedge clk); a1 = a; b1 = b; @(negedge clk);
    endtask
    task automatic apply2(logic [0:0] a, logic [8:0] b);
        @(posedge clk); a2 = a; b2 = b; @(negedge clk);
    endtask

    initial begin
        a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: all-zero inputs
        check("R7 zero inputs wide",   64'(y0), 64'd0);
        check("R7 zero inputs narrow", 64'(y1), 64'd0);
        check("R11 zero inputs bits",  64'(y2), 64'd0);

        // R5: signed product (-1)*(-1)
        apply0(25'h00000FF, 5'd0);             check("R5 signed -1*-1", 64'(y0), 64'd1);
        // R4 R5: (-8)*7 = -56
        apply0(25'h0000078, 5'd0);             check("R4 signed product", 64'(y0), 64'd4040);
        // R6 R5: unsigned 31*7 subtracted
        apply0(25'((31 << 8) | (7 << 13)), 5'd0); check("R6 unsigned subtract", 64'(y0), 64'd3879);
        // R3 R5: single signed operand -32
        apply0(25'(32'h20 << 16), 5'd0);       check("R3 single signed operand", 64'(y0), 64'd4064);
        // R9 R2 R3: operand after the empty record, subtracted
        apply0(25'(7 << 22), 5'd0);            check("R9 slice after empty record", 64'(y0), 64'd4089);
        // R8: increments only
        apply0(25'd0, 5'b10101);               check("R8 increment bits", 64'(y0), 64'd3);

        // R7: overflow wraps to zero; R8 b pin ignored
        apply1(30'h3FFFFFFF, 1'b1);            check("R8 R7 wrap, b ignored", 64'(y1), 64'd0);
        apply1(30'(1 | (3 << 7) | (8 << 14) | (8 << 22)), 1'b0);
        check("R7 narrow wrap", 64'(y1), 64'd61);

        // R11: count wraps at 3 bits, a pin ignored
        apply2(1'b1, 9'h1FF);                  check("R11 count wraps", 64'(y2), 64'd1);
        apply2(1'b0, 9'b000000111);            check("R11 count", 64'(y2), 64'd3);
        apply2(1'b1, 9'd0);                    check("R11 a ignored", 64'(y2), 64'd0);

        // R1 R2 R4 R5 R6: random vectors against the reference model
        for (int k = 0; k < 400; k++) begin
            logic [24:0] ra; logic [4:0] rb;
            ra = 25'($urandom); rb = 5'($urandom);
            apply0(ra, rb);
            check("R1 R2 random wide", 64'(y0), ref_mac(64'(LAY0), 25, 64'(ra), 64'(rb), 5, 12));
        end
        for (int k = 0; k < 400; k++) begin
            logic [29:0] ra; logic [0:0] rb;
            ra = 30'($urandom); rb = 1'($urandom);
            apply1(ra, rb);
            check("R4 R7 random narrow", 64'(y1), ref_mac(64'(LAY1), 30, 64'(ra), 64'(rb), 0, 6));
        end
        for (int k = 0; k < 64; k++) begin
            logic [8:0] rb;
            rb = 9'($urandom);
            apply2(1'($urandom), rb);
            check("R11 random bits", 64'(y2), ref_mac(64'(LAY2), 0, 64'd0, 64'(rb), 9, 3));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule